// File: doc/BRIEF.md
# DDR SDRAM Command Bus Protocol Monitor

This block watches the command bus of a four-bank DDR SDRAM and reports commands that break the protocol. On every rising clock edge it samples clock enable, chip select, the three command strobes, the bank select and the address. It turns them into a command, keeps a model of which banks are open, and runs one countdown per timing rule. A command that breaks a rule raises a one-cycle error pulse carrying a 4-bit code.

The monitor is passive and has no outputs toward the memory. All timing limits are parameters counted in clock cycles. The defaults are: activate-to-access 3, activate-to-activate 2, precharge-to-activate 3, mode-register recovery 2, and a burst of 2 clocks (four beats). A command that breaks a rule is treated as never issued, so one bad command does not cause a cascade of follow-on errors.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With CKE high on this edge and on the previous edge and chip select low, the strobe code {RAS#,CAS#,WE#} decodes as: 000 mode register set, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop. The target bank is BA (0 to 3).
- R2: The error is reported one cycle after the offending edge, as err_valid high for one cycle with a nonzero err_code. When nothing is wrong, err_valid is 0 and err_code is 0. If several rules fail on one edge, the lowest code is reported. A rejected command changes no tracked state.
- R3: A mode register set while any bank is open gives code 2. A refresh, or a self-refresh entry, while any bank is open gives code 3.
- R4: After an accepted mode register set, any command issued fewer than T_MRD (2) cycles later gives code 1. This applies to every command: mode register set, refresh, self-refresh entry, activate, read, write, precharge and burst stop.
- R5: A read or write to an idle bank gives code 4. A read or write fewer than T_RCD (3) cycles after that bank's activate gives code 5.
- R6: An activate to an open bank gives code 7. An activate fewer than T_RRD (2) cycles after the previous accepted activate to any bank gives code 8.
- R7: A precharge with A10 low closes the bank selected by BA. A precharge with A10 high closes every bank, whatever BA holds. An activate fewer than T_RP (3) cycles after its bank closed gives code 9.
- R8: A read or write with A10 high requests auto precharge. Any read or write to that bank during the next BURST_CYC (2) cycles gives code 6. The bank closes at the edge where the burst ends, and T_RP is counted from that edge.
- R9: Chip select high, or code 111, is a no-operation. Burst stop is legal. Neither raises an error or changes any state.
- R10: CKE falling with code 001 and chip select low enters self refresh. Any other CKE fall enters power-down, and power-down entry is never an error. Edges where the previous CKE was low decode nothing and raise no error. Bank state survives the low-power period.
- R11: While reset is held, and in the cycle after it, err_valid and err_code are 0 and all banks are idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Sampled clock enable |
| cs_n | input | 1 | Sampled chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Address; A10 selects all-bank precharge or auto precharge |
| err_valid | output | 1 | One-cycle violation pulse |
| err_code | output | 4 | Code of the reported violation, 0 when none |

## Verification
The assertions assume that every bus input is a known 0 or 1 on each sampled edge, and that reset is held for at least one edge before checking begins. The bench changes inputs only on falling clock edges and resets the block at the start of each scenario. Each scenario therefore begins with all banks idle and all windows expired, and no undriven bit ever reaches the sampled bus. Expected codes come from counting edges against the default cycle limits, so each window is probed on its last illegal edge and its first legal edge.

// File: rtl/ddrmon_pkg.sv
// Package: shared command and error encodings for the command bus monitor.
// Assumes four banks, selected by a 2-bit bank field.
package ddrmon_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BA_W      = 2;
    localparam int ADDR_W    = 13;
    localparam int AP_BIT    = 10;

    typedef enum logic [3:0] {
        CMD_NOP,
        CMD_LOWPWR,
        CMD_PDE,
        CMD_SRE,
        CMD_MRS,
        CMD_REF,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_BST
    } cmd_e;

    localparam logic [3:0] ERR_NONE     = 4'd0;
    localparam logic [3:0] ERR_MRD      = 4'd1;
    localparam logic [3:0] ERR_MRS_OPEN = 4'd2;
    localparam logic [3:0] ERR_REF_OPEN = 4'd3;
    localparam logic [3:0] ERR_RW_IDLE  = 4'd4;
    localparam logic [3:0] ERR_RW_RCD   = 4'd5;
    localparam logic [3:0] ERR_RW_AP    = 4'd6;
    localparam logic [3:0] ERR_ACT_OPEN = 4'd7;
    localparam logic [3:0] ERR_ACT_RRD  = 4'd8;
    localparam logic [3:0] ERR_ACT_RP   = 4'd9;

    // True for every decoded command that occupies a command slot.
    function automatic logic is_issued(input cmd_e c);
        return (c == CMD_MRS) || (c == CMD_REF) || (c == CMD_SRE) ||
               (c == CMD_ACT) || (c == CMD_RD)  || (c == CMD_WR)  ||
               (c == CMD_PRE) || (c == CMD_BST);
    endfunction

endpackage

// File: rtl/ddrmon_countdown.sv
// Module: loadable down-counter that measures a minimum spacing in cycles.
// A load at edge t keeps busy high through edge t+LOAD_VAL, counting the
// value seen at each edge. expiring marks the last busy edge.
module ddrmon_countdown #(
    parameter int LOAD_VAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic expiring
);
    localparam int CW = (LOAD_VAL < 1) ? 1 : $clog2(LOAD_VAL + 1);

    logic [CW-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(LOAD_VAL);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy     = (cnt_q != '0);
    assign expiring = (cnt_q == CW'(1));
endmodule

// File: rtl/ddrmon_decode.sv
// Module: combinational command decoder for one sampled bus edge.
// Assumes cke_prev is CKE as registered on the previous edge.
module ddrmon_decode
    import ddrmon_pkg::*;
(
    input  logic cke,
    input  logic cke_prev,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    logic [2:0] strobes;
    assign strobes = {ras_n, cas_n, we_n};

    // Classify the edge: low-power, CKE fall, or a normal command slot.
    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev) begin
            cmd = CMD_LOWPWR;
        end else if (!cke) begin
            cmd = (!cs_n && strobes == 3'b001) ? CMD_SRE : CMD_PDE;
        end else if (!cs_n) begin
            case (strobes)
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddrmon_bank.sv
// Module: state of one bank: open flag, activate-to-access window,
// pending auto precharge and precharge-to-activate window.
// Assumes the go strobes come only from accepted commands.
module ddrmon_bank #(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic rwap_go,
    input  logic pre_go,
    output logic is_open,
    output logic rcd_busy,
    output logic ap_busy,
    output logic rp_busy
);
    logic open_q, ap_q;
    logic ap_expiring, ap_cnt_busy_unused, rcd_exp_unused, rp_exp_unused;
    logic close_now;

    assign close_now = (pre_go && open_q) || (ap_q && ap_expiring);

    ddrmon_countdown #(.LOAD_VAL(T_RCD - 1)) u_rcd (
        .clk(clk), .rst_n(rst_n), .load(act_go),
        .busy(rcd_busy), .expiring(rcd_exp_unused));

    ddrmon_countdown #(.LOAD_VAL(BURST_CYC)) u_burst (
        .clk(clk), .rst_n(rst_n), .load(rwap_go),
        .busy(ap_cnt_busy_unused), .expiring(ap_expiring));

    ddrmon_countdown #(.LOAD_VAL(T_RP - 1)) u_rp (
        .clk(clk), .rst_n(rst_n), .load(close_now),
        .busy(rp_busy), .expiring(rp_exp_unused));

    // Open on activate, close on precharge or at the end of an auto-precharge burst.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (act_go)
            open_q <= 1'b1;
        else if (close_now)
            open_q <= 1'b0;
    end

    // Remember a pending auto precharge until the bank closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ap_q <= 1'b0;
        else if (close_now)
            ap_q <= 1'b0;
        else if (rwap_go)
            ap_q <= 1'b1;
    end

    assign is_open = open_q;
    assign ap_busy = ap_q;
endmodule

// File: rtl/ddr_cmd_monitor.sv
// Module: top of the command bus monitor. Decodes each edge, checks the
// command against bank state and timing windows, and reports the lowest
// failing code one cycle later. Rejected commands leave state untouched.
// Assumes a single rank with four banks and cycle-counted limits.
module ddr_cmd_monitor
    import ddrmon_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RRD     = 2,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int BURST_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              err_valid,
    output logic [3:0]        err_code
);
    cmd_e                 cmd;
    logic                 cke_q;
    logic [NUM_BANKS-1:0] bank_open, rcd_busy, ap_busy, rp_busy;
    logic [NUM_BANKS-1:0] act_go, rwap_go, pre_go;
    logic                 mrd_busy, rrd_busy;
    logic                 mrd_exp_unused, rrd_exp_unused;
    logic [3:0]           err_next;
    logic                 accept, any_open, ap_flag;
    logic                 addr_unused;

    assign ap_flag     = addr[AP_BIT];
    assign addr_unused = ^{addr[ADDR_W-1:AP_BIT+1], addr[AP_BIT-1:0]};
    assign any_open    = |bank_open;

    // Track CKE from the previous edge to detect low-power entry and exit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cke_q <= 1'b0;
        else
            cke_q <= cke;
    end

    ddrmon_decode u_decode (
        .cke(cke), .cke_prev(cke_q), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd));

    // Rule check in priority order; the first failing rule sets the code.
    always_comb begin
        err_next = ERR_NONE;
        if (is_issued(cmd) && mrd_busy) begin
            err_next = ERR_MRD;
        end else begin
            case (cmd)
                CMD_MRS: if (any_open) err_next = ERR_MRS_OPEN;
                CMD_REF, CMD_SRE: if (any_open) err_next = ERR_REF_OPEN;
                CMD_RD, CMD_WR: begin
                    if (!bank_open[ba])     err_next = ERR_RW_IDLE;
                    else if (rcd_busy[ba])  err_next = ERR_RW_RCD;
                    else if (ap_busy[ba])   err_next = ERR_RW_AP;
                end
                CMD_ACT: begin
                    if (bank_open[ba])      err_next = ERR_ACT_OPEN;
                    else if (rrd_busy)      err_next = ERR_ACT_RRD;
                    else if (rp_busy[ba])   err_next = ERR_ACT_RP;
                end
                default: err_next = ERR_NONE;
            endcase
        end
    end

    assign accept = (err_next == ERR_NONE);

    ddrmon_countdown #(.LOAD_VAL(T_MRD - 1)) u_mrd (
        .clk(clk), .rst_n(rst_n), .load(accept && cmd == CMD_MRS),
        .busy(mrd_busy), .expiring(mrd_exp_unused));

    ddrmon_countdown #(.LOAD_VAL(T_RRD - 1)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(accept && cmd == CMD_ACT),
        .busy(rrd_busy), .expiring(rrd_exp_unused));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel        = (ba == BA_W'(b));
        assign act_go[b]  = accept && cmd == CMD_ACT && sel;
        assign rwap_go[b] = accept && (cmd == CMD_RD || cmd == CMD_WR) && ap_flag && sel;
        assign pre_go[b]  = accept && cmd == CMD_PRE && (ap_flag || sel);

        ddrmon_bank #(.T_RCD(T_RCD), .T_RP(T_RP), .BURST_CYC(BURST_CYC)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_go(act_go[b]), .rwap_go(rwap_go[b]), .pre_go(pre_go[b]),
            .is_open(bank_open[b]), .rcd_busy(rcd_busy[b]),
            .ap_busy(ap_busy[b]), .rp_busy(rp_busy[b]));
    end

    // Register the verdict so the pulse lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_valid <= !accept;
            err_code  <= err_next;
        end
    end
endmodule

// File: rtl/ddrmon_sva.sv
// Module: assertion checker bound to the monitor top.
// Assumes known inputs on every sampled edge once reset has been applied.
module ddrmon_sva
    import ddrmon_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input cmd_e                 cmd,
    input logic                 cke_q,
    input logic [BA_W-1:0]      ba,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 mrd_busy,
    input logic [3:0]           err_next,
    input logic                 err_valid,
    input logic [3:0]           err_code
);
    // R2: a pulse always carries a code
    a_r2_code_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> err_code != 4'd0);

    // R2: no pulse means a zero code
    a_r2_zero_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> err_code == 4'd0);

    // R3: mode register write with an open bank
    a_r3_mrs_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS && |bank_open && !mrd_busy) |=> (err_valid && err_code == ERR_MRS_OPEN));

    // R4: any command inside the recovery window
    a_r4_mrd_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_busy && is_issued(cmd)) |=> (err_valid && err_code == ERR_MRD));

    // R6: activate to an open bank
    a_r6_act_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && bank_open[ba] && !mrd_busy) |=> (err_code == ERR_ACT_OPEN));

    // R6: an accepted activate opens its bank
    a_r6_act_opens_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && err_next == ERR_NONE) |=> bank_open[$past(ba)]);

    // R9: a no-operation never flags
    a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) |=> !err_valid);

    // R10: edges after CKE low never flag
    a_r10_lowpower_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |=> !err_valid);
endmodule

bind ddr_cmd_monitor ddrmon_sva u_ddrmon_sva (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cke_q(cke_q), .ba(ba),
    .bank_open(bank_open), .mrd_busy(mrd_busy), .err_next(err_next),
    .err_valid(err_valid), .err_code(err_code));

// File: tb/test_ddr_cmd_monitor.sv
`timescale 1ns/1ps
module test_ddr_cmd_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic [12:0] addr = 13'd0;
    logic        err_valid;
    logic [3:0]  err_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_ACT = 3'b011,
                           C_RD  = 3'b101, C_WR  = 3'b100, C_PRE = 3'b010,
                           C_BST = 3'b110, C_NOP = 3'b111;

    always #2.5 clk = ~clk;

    ddr_cmd_monitor i_ddr_cmd_monitor (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .err_valid(err_valid), .err_code(err_code));

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (err_valid !== (exp != 4'd0) || err_code !== exp) begin
            errors++;
            $display("FAIL %s: got valid=%b code=%0d, expected valid=%b code=%0d",
                     tag, err_valid, err_code, (exp != 4'd0), exp);
        end
    endtask

    // Drive one bus edge at a falling edge, then check the verdict a cycle later.
    task automatic step(input logic k, input logic csn, input logic [2:0] code,
                        input logic [1:0] b, input logic a10,
                        input logic [3:0] exp, input string tag);
        cke = k; cs_n = csn; {ras_n, cas_n, we_n} = code; ba = b;
        addr = 13'h0A5; addr[10] = a10;
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic cmd(input logic [2:0] code, input logic [1:0] b, input logic a10,
                       input logic [3:0] exp, input string tag);
        step(1'b1, 1'b0, code, b, a10, exp, tag);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, C_NOP, 2'd0, 1'b0, 4'd0, "R9 idle");
    endtask

    task automatic do_reset;
        rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
        repeat (3) @(negedge clk);
        check("R11 outputs in reset", 4'd0);
        rst_n = 1'b1;
        nop(1);   // first edge after reset is a CKE exit edge
        check("R11 outputs after reset", 4'd0);
    endtask

    task automatic t_decode_nop;
        do_reset();
        step(1'b1, 1'b1, C_ACT, 2'd0, 1'b0, 4'd0, "R9 cs high ignored");
        cmd(C_NOP, 2'd0, 1'b0, 4'd0, "R9 code 111 nop");
        cmd(C_BST, 2'd0, 1'b0, 4'd0, "R9 burst stop legal");
        cmd(C_RD,  2'd0, 1'b0, 4'd4, "R9 R1 bank 0 still idle");
        cmd(C_WR,  2'd3, 1'b0, 4'd4, "R1 R5 write to idle bank 3");
    endtask

    task automatic t_mrd;
        do_reset();
        cmd(C_MRS, 2'd0, 1'b0, 4'd0, "R3 mrs all idle");
        cmd(C_ACT, 2'd0, 1'b0, 4'd1, "R4 act inside recovery");
        cmd(C_ACT, 2'd0, 1'b0, 4'd0, "R4 R2 act after recovery, prior one dropped");
    endtask

    task automatic t_busy_banks;
        do_reset();
        cmd(C_ACT, 2'd1, 1'b0, 4'd0, "R6 act bank 1");
        cmd(C_MRS, 2'd0, 1'b0, 4'd2, "R3 mrs with open bank");
        cmd(C_REF, 2'd0, 1'b0, 4'd3, "R3 refresh with open bank");
        cmd(C_ACT, 2'd1, 1'b0, 4'd7, "R6 act to open bank");
    endtask

    task automatic t_rcd;
        do_reset();
        cmd(C_ACT, 2'd1, 1'b0, 4'd0, "R5 act bank 1");
        cmd(C_RD,  2'd1, 1'b0, 4'd5, "R5 read 1 cycle after act");
        cmd(C_WR,  2'd1, 1'b0, 4'd5, "R5 write 2 cycles after act");
        cmd(C_RD,  2'd1, 1'b0, 4'd0, "R5 read 3 cycles after act");
        cmd(C_RD,  2'd2, 1'b0, 4'd4, "R5 read idle bank 2");
    endtask

    task automatic t_rrd;
        do_reset();
        cmd(C_ACT, 2'd0, 1'b0, 4'd0, "R6 act bank 0");
        cmd(C_ACT, 2'd1, 1'b0, 4'd8, "R6 act spacing 1");
        cmd(C_ACT, 2'd1, 1'b0, 4'd0, "R6 act spacing 2");
    endtask

    task automatic t_pre;
        do_reset();
        cmd(C_ACT, 2'd2, 1'b0, 4'd0, "R7 act bank 2");
        cmd(C_PRE, 2'd2, 1'b0, 4'd0, "R7 precharge bank 2");
        cmd(C_ACT, 2'd2, 1'b0, 4'd9, "R7 act 1 after precharge");
        cmd(C_ACT, 2'd2, 1'b0, 4'd9, "R7 act 2 after precharge");
        cmd(C_ACT, 2'd2, 1'b0, 4'd0, "R7 act 3 after precharge");
    endtask

    task automatic t_pre_all;
        do_reset();
        cmd(C_ACT, 2'd0, 1'b0, 4'd0, "R7 act bank 0");
        nop(1);
        cmd(C_ACT, 2'd3, 1'b0, 4'd0, "R7 act bank 3");
        nop(3);
        cmd(C_PRE, 2'd1, 1'b1, 4'd0, "R7 precharge all, BA=1");
        cmd(C_RD,  2'd0, 1'b0, 4'd4, "R7 bank 0 closed by all-bank precharge");
        cmd(C_RD,  2'd3, 1'b0, 4'd4, "R7 bank 3 closed by all-bank precharge");
        cmd(C_REF, 2'd0, 1'b0, 4'd0, "R3 refresh all idle");
    endtask

    task automatic t_autopre;
        do_reset();
        cmd(C_ACT, 2'd1, 1'b0, 4'd0, "R8 act bank 1");
        nop(2);
        cmd(C_WR,  2'd1, 1'b1, 4'd0, "R8 write with auto precharge");
        cmd(C_RD,  2'd1, 1'b0, 4'd6, "R8 read during burst 1");
        cmd(C_RD,  2'd1, 1'b0, 4'd6, "R8 read during burst 2");
        cmd(C_RD,  2'd1, 1'b0, 4'd4, "R8 bank closed after burst");
        cmd(C_ACT, 2'd1, 1'b0, 4'd9, "R8 act before precharge time");
        cmd(C_ACT, 2'd1, 1'b0, 4'd0, "R8 act after precharge time");
    endtask

    task automatic t_selfref;
        do_reset();
        cmd(C_ACT, 2'd0, 1'b0, 4'd0, "R10 act bank 0");
        nop(1);
        step(1'b0, 1'b0, C_REF, 2'd0, 1'b0, 4'd3, "R3 R10 self refresh entry with open bank");
        step(1'b0, 1'b0, C_MRS, 2'd0, 1'b0, 4'd0, "R10 mrs code while CKE low");
        step(1'b0, 1'b0, C_ACT, 2'd0, 1'b0, 4'd0, "R10 act code while CKE low");
        step(1'b1, 1'b1, C_NOP, 2'd0, 1'b0, 4'd0, "R10 exit edge");
        cmd(C_RD,  2'd0, 1'b0, 4'd0, "R10 bank 0 kept open");
        cmd(C_PRE, 2'd0, 1'b1, 4'd0, "R7 precharge all");
        step(1'b0, 1'b0, C_REF, 2'd0, 1'b0, 4'd0, "R10 self refresh entry all idle");
        step(1'b0, 1'b1, C_NOP, 2'd0, 1'b0, 4'd0, "R10 self refresh hold");
        step(1'b1, 1'b1, C_NOP, 2'd0, 1'b0, 4'd0, "R10 self refresh exit");
    endtask

    task automatic t_powerdown;
        do_reset();
        cmd(C_ACT, 2'd2, 1'b0, 4'd0, "R10 act bank 2");
        nop(1);
        step(1'b0, 1'b1, C_NOP, 2'd0, 1'b0, 4'd0, "R10 power-down entry with open bank");
        step(1'b0, 1'b0, C_MRS, 2'd0, 1'b0, 4'd0, "R10 mrs code in power-down");
        step(1'b1, 1'b1, C_NOP, 2'd0, 1'b0, 4'd0, "R10 power-down exit");
        cmd(C_RD,  2'd2, 1'b0, 4'd0, "R10 bank 2 kept open");
        cmd(C_ACT, 2'd2, 1'b0, 4'd7, "R10 R6 bank 2 still open");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_decode_nop();
        t_mrd();
        t_busy_banks();
        t_rcd();
        t_rrd();
        t_pre();
        t_pre_all();
        t_autopre();
        t_selfref();
        t_powerdown();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end
endmodule